// File: doc/BRIEF.md
# Sync-Checking Serial Word Deserializer

This block takes a recovered serial bit stream, one bit per cycle in which a bit strobe is high, and rebuilds parallel words from it. On the line, every data byte is preceded by one framing bit that must read logic 1. The block checks each framing bit at its slot and drops it. It shifts the eight data bits that follow into a word assembler. A mode input, sampled when a frame opens, sets the word to two or four bytes.

A frame opens when the line-active input rises, which means the bus has left its idle, cut-off state. Busy is asserted from that point. When the last data bit is captured, the finished word goes into a 32-bit receive register, a full flag is set, and busy drops. The host empties the register with a read strobe.

Two sticky error bits are kept. One records a framing bit that was missing, and that frame is then abandoned. The other records a word that arrived while the register was still full. An error output is the OR of both bits. Clock recovery and the analog line receiver are outside this block.

Top module: `syncword_rx`

## Requirements
- R1: After reset, busy, rx_full, sync_err, overrun_err and err_any are 0 and rx_word is 0.
- R2: A frame opens only on a rising edge of line_active. Busy is high in the cycle after the edge at which line_active is first sampled high. If line_active simply stays high after a frame ends, no new frame opens.
- R3: Each byte slot is nine strobed bits. The first is a framing bit that must be 1 and is discarded. Eight data bits follow, most significant first, and the bytes of a word arrive most significant byte first.
- R4: With wide_mode = 1 at frame open, four bytes make the word. At the clock edge that captures the last data bit, rx_word takes the word, rx_full goes to 1 and busy goes to 0.
- R5: With wide_mode = 0 at frame open, two bytes make the word, which is loaded zero-extended into rx_word[15:0]. A change of wide_mode during a frame has no effect on that frame.
- R6: A 0 in a framing-bit slot sets sync_err and drops busy at that edge. The frame is abandoned, and rx_word and rx_full are left unchanged.
- R7: sync_err and overrun_err stay set until err_clear is high at a clock edge. If a new error and err_clear occur in the same cycle, the error bit ends up set.
- R8: rd_strobe clears rx_full. If a word completes in the same cycle as rd_strobe, the new word is loaded, rx_full stays 1 and no overrun is flagged.
- R9: If a word completes while rx_full is 1 and rd_strobe is low, overrun_err is set and rx_word keeps the unread word.
- R10: If line_active falls while busy, busy is 0 in the next cycle and the partial frame is discarded without loading.
- R11: err_any is 1 exactly when sync_err or overrun_err is 1.
- R12: Bits are taken only in cycles where bit_valid is high. Gaps of any length between bits do not disturb the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_active | input | 1 | High while the bus is out of its idle cut-off state |
| bit_valid | input | 1 | Strobe marking a cycle that carries a serial bit |
| bit_in | input | 1 | Serial data bit |
| wide_mode | input | 1 | 1 selects 32-bit words, 0 selects 16-bit words (sampled at frame open) |
| rd_strobe | input | 1 | Host read, empties the receive register |
| err_clear | input | 1 | Clears both error bits |
| busy | output | 1 | Frame reception in progress |
| rx_word | output | 32 | Receive register |
| rx_full | output | 1 | Receive register holds an unread word |
| sync_err | output | 1 | Sticky missing-framing-bit error |
| overrun_err | output | 1 | Sticky overrun error |
| err_any | output | 1 | OR of the error bits |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-bit bytes and 16-bit narrow words. This gives real nine-bit slots and both the two-byte and four-byte frame lengths, so the byte-count wrap differs between modes. With these values the same-cycle collisions are exercised directly: load with read, and error with clear. Mid-frame line loss and bad framing bits in a later byte are also exercised, along with bit-strobe gaps, a frame reopened after an abandoned one, and a mode change in the middle of a frame.

// File: rtl/syncword_rx_pkg.sv
package syncword_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SYNC = 2'd1,
        FR_DATA = 2'd2
    } frame_state_e;

    // Per-cycle events issued by the framing controller
    typedef struct packed {
        logic restart;    // new frame opened, clear assembler
        logic shift;      // data bit accepted
        logic done;       // last data bit of the word accepted
        logic sync_miss;  // framing bit absent
    } frame_evt_t;

    typedef struct packed {
        logic overrun;
        logic sync;
    } rx_err_t;

    localparam logic SYNC_LEVEL = 1'b1;

    function automatic int unsigned bytes_per_word(input logic wide,
                                                   input int unsigned word_w,
                                                   input int unsigned byte_w);
        return wide ? (word_w / byte_w) : (word_w / (2 * byte_w));
    endfunction

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import syncword_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_active,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       wide_mode,
    output frame_evt_t evt,
    output logic       busy
);
    localparam int unsigned MAX_BYTES = WORD_W / BYTE_W;
    localparam int unsigned BIT_CW    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int unsigned BYTE_CW   = $clog2(MAX_BYTES + 1);
    localparam logic [BIT_CW-1:0]  LAST_BIT    = BIT_CW'(BYTE_W - 1);
    localparam logic [BYTE_CW-1:0] LAST_WIDE   =
        BYTE_CW'(bytes_per_word(1'b1, WORD_W, BYTE_W) - 1);
    localparam logic [BYTE_CW-1:0] LAST_NARROW =
        BYTE_CW'(bytes_per_word(1'b0, WORD_W, BYTE_W) - 1);

    frame_state_e       state_q, state_d;
    logic [BIT_CW-1:0]  bit_q, bit_d;
    logic [BYTE_CW-1:0] byte_q, byte_d;
    logic               wide_q, wide_d;
    logic               line_q;
    logic               line_rise;
    logic               last_byte;

    assign line_rise = line_active & ~line_q;
    assign last_byte = (byte_q == (wide_q ? LAST_WIDE : LAST_NARROW));

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        byte_d  = byte_q;
        wide_d  = wide_q;
        evt     = '0;
        unique case (state_q)
            FR_IDLE: begin
                if (line_rise) begin
                    state_d     = FR_SYNC;
                    byte_d      = '0;
                    bit_d       = '0;
                    wide_d      = wide_mode;
                    evt.restart = 1'b1;
                end
            end
            FR_SYNC: begin
                if (!line_active) begin
                    state_d = FR_IDLE;
                end else if (bit_valid) begin
                    if (bit_in == SYNC_LEVEL) begin
                        state_d = FR_DATA;
                        bit_d   = '0;
                    end else begin
                        state_d       = FR_IDLE;
                        evt.sync_miss = 1'b1;
                    end
                end
            end
            FR_DATA: begin
                if (!line_active) begin
                    state_d = FR_IDLE;
                end else if (bit_valid) begin
                    evt.shift = 1'b1;
                    if (bit_q == LAST_BIT) begin
                        if (last_byte) begin
                            evt.done = 1'b1;
                            state_d  = FR_IDLE;
                        end else begin
                            byte_d  = byte_q + 1'b1;
                            state_d = FR_SYNC;
                        end
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            bit_q   <= '0;
            byte_q  <= '0;
            wide_q  <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            wide_q  <= wide_d;
            line_q  <= line_active;
        end
    end

    assign busy = (state_q != FR_IDLE);

endmodule

// File: rtl/rx_shift_asm.sv
module rx_shift_asm
    import syncword_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_evt_t        evt,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-2:0] shreg_q;

    // Word as it stands including the bit on the line this cycle
    assign word_next = {shreg_q, bit_in};

    always_ff @(posedge clk) begin
        if (rst || evt.restart) begin
            shreg_q <= '0;
        end else if (evt.shift) begin
            shreg_q <= word_next[WORD_W-2:0];
        end
    end

endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
    import syncword_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_evt_t        evt,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_strobe,
    input  logic              err_clear,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_full,
    output rx_err_t           err
);
    logic load;
    logic overrun_evt;

    assign load        = evt.done & (~rx_full | rd_strobe);
    assign overrun_evt = evt.done & rx_full & ~rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
            rx_full <= 1'b0;
            err     <= '0;
        end else begin
            if (load) begin
                rx_word <= word_in;
            end
            if (evt.done) begin
                rx_full <= 1'b1;
            end else if (rd_strobe) begin
                rx_full <= 1'b0;
            end
            if (evt.sync_miss) begin
                err.sync <= 1'b1;
            end else if (err_clear) begin
                err.sync <= 1'b0;
            end
            if (overrun_evt) begin
                err.overrun <= 1'b1;
            end else if (err_clear) begin
                err.overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/syncword_rx.sv
module syncword_rx
    import syncword_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_active,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              wide_mode,
    input  logic              rd_strobe,
    input  logic              err_clear,
    output logic              busy,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_full,
    output logic              sync_err,
    output logic              overrun_err,
    output logic              err_any
);
    frame_evt_t        evt;
    logic [WORD_W-1:0] word_next;
    rx_err_t           err;

    rx_frame_ctrl #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .line_active (line_active),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .wide_mode   (wide_mode),
        .evt         (evt),
        .busy        (busy)
    );

    rx_shift_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .bit_in    (bit_in),
        .word_next (word_next)
    );

    rx_hold_regs #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .word_in   (word_next),
        .rd_strobe (rd_strobe),
        .err_clear (err_clear),
        .rx_word   (rx_word),
        .rx_full   (rx_full),
        .err       (err)
    );

    assign sync_err    = err.sync;
    assign overrun_err = err.overrun;
    assign err_any     = |err;

endmodule

// File: rtl/syncword_rx_chk.sv
module syncword_rx_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              line_active,
    input logic              bit_valid,
    input logic              rd_strobe,
    input logic              err_clear,
    input logic              busy,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_full,
    input logic              sync_err
);
    // R2: busy only rises after the line was seen active
    p_busy_from_line_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(line_active));

    // R4: a fresh full flag ends a frame
    p_full_ends_frame_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> ($past(busy) && !busy));

    // R6: a framing failure leaves the block idle
    p_sync_abandons_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> !busy);

    // R7: error is sticky without a clear
    p_sticky_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_err && !err_clear) |=> sync_err);

    // R8: full is held until read
    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_strobe) |=> rx_full);

    // R9: unread word is never overwritten
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_strobe) |=> $stable(rx_word));

    // R10: idle line ends reception
    p_idle_drops_r10: assert property (@(posedge clk) disable iff (rst)
        !line_active |=> !busy);

    // R12: strobe gaps do not end a frame
    p_gap_keeps_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && line_active && !bit_valid) |=> busy);

endmodule

bind syncword_rx syncword_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_active (line_active),
    .bit_valid   (bit_valid),
    .rd_strobe   (rd_strobe),
    .err_clear   (err_clear),
    .busy        (busy),
    .rx_word     (rx_word),
    .rx_full     (rx_full),
    .sync_err    (sync_err)
);

// File: tb/syncword_rx_bench.sv
`timescale 1ns/1ps
module syncword_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_active = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        wide_mode = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        err_clear = 1'b0;
    logic        busy, rx_full, sync_err, overrun_err, err_any;
    logic [31:0] rx_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    syncword_rx u_syncword_rx (
        .clk(clk), .rst(rst), .line_active(line_active), .bit_valid(bit_valid),
        .bit_in(bit_in), .wide_mode(wide_mode), .rd_strobe(rd_strobe),
        .err_clear(err_clear), .busy(busy), .rx_word(rx_word), .rx_full(rx_full),
        .sync_err(sync_err), .overrun_err(overrun_err), .err_any(err_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bit i of a framed stream: framing bit then 8 data bits per byte
    function automatic logic frame_bit(input logic [31:0] word, input int nbytes,
                                       input int bad_byte, input int i);
        int slot = i % 9;
        int b    = i / 9;
        if (slot == 0) return (b == bad_byte) ? 1'b0 : 1'b1;
        return word[nbytes*8 - 1 - (b*8 + slot - 1)];
    endfunction

    task automatic line_idle();
        @(negedge clk); line_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_frame(input logic wide);
        @(negedge clk); line_active = 1'b1; wide_mode = wide;
        @(negedge clk);
    endtask

    task automatic drive_bits(input logic [31:0] word, input int nbytes, input int bad_byte,
                              input int count, input int gap, input logic rd_last,
                              input logic clr_last);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            bit_in    = frame_bit(word, nbytes, bad_byte, i);
            bit_valid = 1'b1;
            rd_strobe = rd_last && (i == count - 1);
            err_clear = clr_last && (i == count - 1);
            @(negedge clk);
            bit_valid = 1'b0; rd_strobe = 1'b0; err_clear = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic host_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic host_clear();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 full", rx_full, 0);
        chk("R1 sync_err", sync_err, 0);
        chk("R1 overrun", overrun_err, 0);
        chk("R1 err_any", err_any, 0);
        chk("R1 word", rx_word, 0);
    endtask

    task automatic t_wide_gaps();
        open_frame(1'b1);
        chk("R2 busy after open", busy, 1);
        drive_bits(32'hA5C3_1E7F, 4, -1, 36, 2, 1'b0, 1'b0);
        chk("R4 R3 R12 wide word", rx_word, 32'hA5C3_1E7F);
        chk("R4 full", rx_full, 1);
        chk("R4 busy low", busy, 0);
        chk("R11 no error", err_any, 0);
    endtask

    task automatic t_level_no_restart();
        drive_bits(32'hFFFF_FFFF, 4, -1, 9, 0, 1'b0, 1'b0);
        chk("R2 no reopen busy", busy, 0);
        chk("R2 no reopen word", rx_word, 32'hA5C3_1E7F);
        line_idle();
        host_read();
        chk("R8 read clears full", rx_full, 0);
        chk("R8 word kept after read", rx_word, 32'hA5C3_1E7F);
    endtask

    task automatic t_narrow();
        open_frame(1'b0);
        @(negedge clk); wide_mode = 1'b1;
        drive_bits(32'h0000_BEEF, 2, -1, 18, 0, 1'b0, 1'b0);
        chk("R5 narrow word", rx_word, 32'h0000_BEEF);
        chk("R5 full after two bytes", rx_full, 1);
        chk("R5 busy low after two bytes", busy, 0);
        line_idle();
    endtask

    task automatic t_overrun();
        open_frame(1'b0);
        drive_bits(32'h0000_1234, 2, -1, 18, 0, 1'b0, 1'b0);
        chk("R9 overrun set", overrun_err, 1);
        chk("R9 word kept", rx_word, 32'h0000_BEEF);
        chk("R9 full", rx_full, 1);
        chk("R11 err_any on overrun", err_any, 1);
        line_idle();
        host_clear();
        chk("R7 overrun cleared", overrun_err, 0);
        chk("R11 err_any cleared", err_any, 0);
        host_read();
    endtask

    task automatic t_sync_err();
        open_frame(1'b1);
        drive_bits(32'h1122_3344, 4, 2, 19, 0, 1'b0, 1'b1);
        chk("R6 R7 sync_err set wins", sync_err, 1);
        chk("R6 busy low", busy, 0);
        chk("R6 full unchanged", rx_full, 0);
        chk("R6 word unchanged", rx_word, 32'h0000_BEEF);
        drive_bits(32'h1122_3344, 4, -1, 20, 0, 1'b0, 1'b0);
        chk("R6 rest ignored", rx_full, 0);
        chk("R7 sync_err sticky", sync_err, 1);
        chk("R11 err_any on sync", err_any, 1);
        line_idle();
        host_clear();
        chk("R7 sync_err cleared", sync_err, 0);
    endtask

    task automatic t_line_drop();
        open_frame(1'b1);
        drive_bits(32'h7777_7777, 4, -1, 12, 0, 1'b0, 1'b0);
        @(negedge clk); line_active = 1'b0;
        @(negedge clk);
        chk("R10 busy low", busy, 0);
        chk("R10 no load", rx_full, 0);
        open_frame(1'b1);
        drive_bits(32'hDEAD_BEEF, 4, -1, 36, 0, 1'b0, 1'b0);
        chk("R10 R3 clean restart", rx_word, 32'hDEAD_BEEF);
        line_idle();
    endtask

    task automatic t_read_and_load();
        open_frame(1'b1);
        drive_bits(32'h0F0F_00FF, 4, -1, 36, 1, 1'b1, 1'b0);
        chk("R8 new word loaded", rx_word, 32'h0F0F_00FF);
        chk("R8 full stays", rx_full, 1);
        chk("R8 no overrun", overrun_err, 0);
        line_idle();
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_gaps();
        t_level_no_restart();
        t_narrow();
        t_overrun();
        t_sync_err();
        t_line_drop();
        t_read_and_load();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule